// File: doc/BRIEF.md
# Three-decade latched BCD counter

This block counts falling edges of a slow event input across three cascaded decimal decades (ones, tens, hundreds), covering 000 to 999. The event input is sampled on the system clock and a 1-to-0 transition of it is one count. A hold input freezes the count without losing it, and a synchronous master reset clears all three decades.

Each decade feeds a 4-bit snapshot register. While the snapshot enable is low, the digit outputs show the live count. While it is high, they show the count that was present when it rose, even across a master reset, so a reading can be taken while the counter is cleared and restarted. An overflow flag rises when the count wraps from 999 to 000 and falls on the next count. Its falling edge can serve as the count event of a further stage.

Top module: `bcd3_latch_counter`

## Requirements
- R1: A 1-to-0 transition of `count_in`, seen between two samples on `clk`, advances the count by one at the clock edge that sees the low level. A 0-to-1 transition leaves the count unchanged.
- R2: The ones decade wraps from 9 to 0 and carries into tens, and tens carries into hundreds, on the same edge. A count of 099 advances to 100.
- R3: While `count_hold` is high, falling transitions of `count_in` are ignored and the count is kept.
- R4: `master_reset` high at a clock edge clears all three decades and the overflow flag. This takes priority over counting and over `count_hold`.
- R5: While `latch_en` is low, the digit outputs equal the live count of the same cycle.
- R6: While `latch_en` is high, the digit outputs keep the count present when it rose, and counting continues underneath. When `latch_en` drops, the outputs show the live count again.
- R7: A snapshot held by `latch_en` stays on the outputs through a master reset. After `latch_en` drops, the outputs show the cleared count.
- R8: `overflow` is set on the count that wraps 999 to 000 and cleared on the next count. It is low otherwise, so it gives one pulse per 1000 counts.
- R9: Each digit bus carries 8421 BCD, active high, with bit 3 the most significant, and never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| count_in | input | 1 | Event input; each falling transition is one count |
| count_hold | input | 1 | High: ignore count events, keep the count |
| latch_en | input | 1 | High: freeze digit outputs at the snapshot |
| master_reset | input | 1 | Synchronous clear of decades and overflow |
| dig_ones | output | 4 | BCD ones digit (snapshot or live) |
| dig_tens | output | 4 | BCD tens digit (snapshot or live) |
| dig_hunds | output | 4 | BCD hundreds digit (snapshot or live) |
| overflow | output | 1 | High from the 999-to-000 wrap until the next count |

## Verification
A falling event, a reset or a hold takes effect at the first rising clock edge that samples the new input level, so the digits and `overflow` are due one edge after the stimulus is applied. A change of `latch_en` alone acts on the outputs without any clock delay. The bench drives every input on the falling clock edge. It advances its reference model right after the rising edge, using the inputs of that cycle, and compares the outputs at the next falling edge, before it drives new inputs. Each result is therefore compared exactly one edge after the stimulus that caused it.

// File: rtl/bcd3_latch_counter.sv
module bcd3_latch_counter (
  input  logic       clk,
  input  logic       count_in,
  input  logic       count_hold,
  input  logic       latch_en,
  input  logic       master_reset,
  output logic [3:0] dig_ones,
  output logic [3:0] dig_tens,
  output logic [3:0] dig_hunds,
  output logic       overflow
);
  localparam int          DW  = 4;
  localparam logic [DW-1:0] TOP = DW'(9);

  logic          in_q;
  logic          ovf_q;
  logic          started_q = 1'b0;
  logic [DW-1:0] ones_q, tens_q, hund_q;
  logic [DW-1:0] ones_n, tens_n, hund_n;
  logic [DW-1:0] snap_o, snap_t, snap_h;

  wire fall   = in_q & ~count_in;
  wire step   = fall & ~count_hold & ~master_reset;
  wire c_ones = step & (ones_q == TOP);
  wire c_tens = c_ones & (tens_q == TOP);
  wire c_hund = c_tens & (hund_q == TOP);

  always_comb begin
    ones_n = ones_q;
    tens_n = tens_q;
    hund_n = hund_q;
    if (master_reset) begin
      ones_n = '0;
      tens_n = '0;
      hund_n = '0;
    end else if (step) begin
      ones_n = c_ones ? '0 : ones_q + 1'b1;
      if (c_ones) tens_n = c_tens ? '0 : tens_q + 1'b1;
      if (c_tens) hund_n = c_hund ? '0 : hund_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    in_q   <= count_in;
    ones_q <= ones_n;
    tens_q <= tens_n;
    hund_q <= hund_n;
    if (master_reset) begin
      ovf_q     <= 1'b0;
      started_q <= 1'b1;
    end else if (step) begin
      ovf_q <= c_hund;
    end
    if (!latch_en) begin
      snap_o <= ones_n;
      snap_t <= tens_n;
      snap_h <= hund_n;
    end
  end

  assign dig_ones  = latch_en ? snap_o : ones_q;
  assign dig_tens  = latch_en ? snap_t : tens_q;
  assign dig_hunds = latch_en ? snap_h : hund_q;
  assign overflow  = ovf_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!started_q)
    master_reset |=> ({hund_q, tens_q, ones_q} == 12'h000 && !overflow)); // R4

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (master_reset)
    (count_hold && started_q) |=> $stable({hund_q, tens_q, ones_q})); // R3

  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!started_q)
    (latch_en && $past(latch_en)) |-> $stable({dig_hunds, dig_tens, dig_ones})); // R6

  AST_OVF_AT_WRAP: assert property (@(posedge clk) disable iff (master_reset || !started_q)
    $rose(overflow) |-> ($past({hund_q, tens_q, ones_q}) == 12'h999)); // R8

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!started_q)
    (dig_ones <= TOP) && (dig_tens <= TOP) && (dig_hunds <= TOP)); // R9

  AST_ONES_WRAP: assert property (@(posedge clk) disable iff (master_reset || !started_q)
    (step && ones_q == TOP) |=> (ones_q == '0)); // R2
endmodule

// File: tb/test_bcd3_latch_counter.sv
module test_bcd3_latch_counter;
  logic clk = 1'b0;
  logic count_in = 1'b0, count_hold = 1'b0, latch_en = 1'b0, master_reset = 1'b1;
  logic [3:0] dig_ones, dig_tens, dig_hunds;
  logic overflow;

  bcd3_latch_counter i_bcd3_latch_counter (
    .clk(clk), .count_in(count_in), .count_hold(count_hold), .latch_en(latch_en),
    .master_reset(master_reset), .dig_ones(dig_ones), .dig_tens(dig_tens),
    .dig_hunds(dig_hunds), .overflow(overflow));

  always #2.5 clk = ~clk;

  int    checks = 0, errors = 0;
  int    cnt = 0, snap = 0;
  bit    prev_cin = 1'b0, ovf = 1'b0, le_cur = 1'b0, armed = 1'b0, done = 1'b0;
  bit    hold_v = 1'b0, le_v = 1'b0;
  string tag = "R4";

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check_out();
    logic [11:0] exp_d, got_d;
    exp_d = to_bcd(le_cur ? snap : cnt);
    got_d = {dig_hunds, dig_tens, dig_ones};
    checks++;
    if (got_d !== exp_d || overflow !== ovf) begin
      errors++;
      $display("FAIL %s: digits=%h ovf=%b expected digits=%h ovf=%b",
               tag, got_d, overflow, exp_d, ovf);
    end
  endtask

  task automatic cyc(bit cin, bit hold, bit le, bit mr);
    bit fall;
    @(negedge clk);
    if (armed) check_out();
    count_in = cin; count_hold = hold; latch_en = le; master_reset = mr;
    le_cur = le;
    @(posedge clk);
    fall = prev_cin && !cin;
    prev_cin = cin;
    if (mr) begin
      cnt = 0; ovf = 1'b0;
    end else if (fall && !hold) begin
      if (cnt == 999) begin cnt = 0; ovf = 1'b1; end
      else begin cnt = cnt + 1; ovf = 1'b0; end
    end
    if (!le) snap = cnt;
  endtask

  task automatic pulse(int n);
    for (int k = 0; k < n; k++) begin
      cyc(1'b1, hold_v, le_v, 1'b0);
      cyc(1'b0, hold_v, le_v, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd1553));
    // R4: reset state
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b0, 1'b1);
    armed = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    // R1: falling transitions count, rising ones do not
    tag = "R1";
    pulse(7);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    // R2: carries through 099 -> 100
    tag = "R2";
    pulse(92);
    pulse(1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    // R3: hold ignores events
    tag = "R3";
    hold_v = 1'b1; pulse(10); hold_v = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    // R5: transparent outputs
    tag = "R5";
    pulse(5);
    // R6: frozen snapshot while counting continues
    tag = "R6";
    le_v = 1'b1; pulse(20); le_v = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    // R7: snapshot survives reset
    tag = "R7";
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    // R4: reset wins over hold and an event
    tag = "R4";
    pulse(3);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    // R8: wrap 999 -> 000 sets overflow, next count clears it
    tag = "R8";
    pulse(999);
    pulse(1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    pulse(1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    // R9: constrained random mix
    tag = "R9";
    for (int k = 0; k < 6000; k++) begin
      bit c, h, l, r;
      c = $urandom_range(0, 1) == 1;
      h = $urandom_range(0, 7) == 0;
      if ($urandom_range(0, 15) == 0) le_v = ~le_v;
      l = le_v;
      r = $urandom_range(0, 499) == 0;
      cyc(c, h, l, r);
    end
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule